// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block keeps three bit sets over a 256-entry vector space: requests waiting for service, vectors currently being serviced, and a per-vector trigger flag that records level or edge. Vectors are grouped into sixteen classes of sixteen, and a class is the upper nibble of the vector number. A processor priority is derived from the software-written task priority and the class of the highest vector in service. A waiting vector is offered to the core only when its class is strictly above that priority.

Requests arrive on a one-cycle port that carries a vector and a trigger flag. The port reports at once whether the request was taken. The core acknowledges with a single strobe, and one cycle later the block returns the vector that moved from waiting to in service. An end-of-interrupt strobe retires the highest in-service vector, and one cycle later the block reports that vector together with its trigger kind, so that a level source can be re-armed. Every state change happens on the clock edge after the strobe, and decisions in a cycle are made on the state held before that edge.

Top module: `irq_prio_core`

## Requirements
- R1: A synchronous reset clears every waiting, in-service and trigger bit and sets the task priority to 0. After reset ppr_o, int_pending_o, int_vector_o, ack_done_o and eoi_done_o are all 0.
- R2: A request is accepted (req_accept_o high in the same cycle) when enable_i is 1, the vector is 16 or above, and its waiting bit is clear. The waiting bit is set at the next edge, and the trigger bit is set to req_level_i, where 1 means level and 0 means edge.
- R3: A request for a vector whose waiting bit is already set is refused (req_accept_o low), and state is unchanged.
- R4: A request is refused, with no change, while enable_i is 0 or when the vector is below 16.
- R5: ppr_o equals the stored task priority when its upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. With nothing in service, the in-service term is 0.
- R6: int_pending_o is 1 exactly when some vector is waiting and the highest waiting vector with its low nibble cleared is strictly greater than ppr_o.
- R7: int_vector_o is the highest-numbered waiting vector, or 0 when none is waiting.
- R8: ack_i while int_pending_o is 1 moves int_vector_o from waiting to in service. In the next cycle ack_done_o is 1 and ack_vector_o holds that vector. ack_i without int_pending_o has no effect, and ack_done_o stays 0.
- R9: eoi_i while some vector is in service clears the highest in-service bit and its trigger bit. In the next cycle eoi_done_o is 1, eoi_vector_o holds that vector, and eoi_level_o holds its trigger bit as it was before clearing.
- R10: eoi_i with nothing in service changes nothing, and eoi_done_o stays 0.
- R11: A task priority write (tpr_we_i) stores only tpr_wdata_i[7:0]. The new value takes effect from the next cycle.
- R12: Within one cycle, a request is judged against the state before the edge. If an end-of-interrupt and an accepted request name the same vector, the request's trigger flag is the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Controller enabled; requests are refused while low |
| req_valid_i | input | 1 | Request strobe |
| req_vector_i | input | 8 | Requested vector |
| req_level_i | input | 1 | Trigger kind of the request: 1 level, 0 edge |
| req_accept_o | output | 1 | Request taken this cycle |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 32 | Task priority write data (low 8 bits kept) |
| ppr_o | output | 8 | Current processor priority |
| int_pending_o | output | 1 | A deliverable vector exists |
| int_vector_o | output | 8 | Highest waiting vector |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_done_o | output | 1 | Acknowledge took effect in the previous cycle |
| ack_vector_o | output | 8 | Vector moved to in service (0 when ack_done_o is low) |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_done_o | output | 1 | A vector was retired in the previous cycle |
| eoi_vector_o | output | 8 | Retired vector (0 when eoi_done_o is low) |
| eoi_level_o | output | 1 | Retired vector was level triggered |

## Verification
The hardest case to reach from the ports is a retirement and a new request that land on the same vector in the same cycle. To get there, the vector must first be requested as level and acknowledged. It is then requested again as edge in the very cycle the end-of-interrupt strobe arrives. A directed sequence builds exactly this case and the equal-class masking boundary. A long pseudo-random phase then mixes nested acknowledges, retirements and priority writes, and a behavioural model compares every output on every cycle.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;
  localparam int SUB_W   = VEC_W - CLASS_W;

  typedef logic [VEC_W-1:0] vec_t;

  // vector with its sub-class bits cleared
  function automatic vec_t class_base(vec_t v);
    return {v[VEC_W-1 -: CLASS_W], {SUB_W{1'b0}}};
  endfunction

  // processor priority from task priority and top in-service vector
  function automatic vec_t calc_ppr(vec_t tpr, logic isr_any, vec_t isr_top);
    vec_t isrv;
    isrv = isr_any ? isr_top : '0;
    if (tpr[VEC_W-1 -: CLASS_W] >= isrv[VEC_W-1 -: CLASS_W])
      return tpr;
    return class_base(isrv);
  endfunction

  // a waiting vector is offered only when its class beats the priority
  function automatic logic can_deliver(logic irr_any, vec_t irr_top, vec_t ppr);
    return irr_any && (class_base(irr_top) > ppr);
  endfunction
endpackage

// File: rtl/irq_prio_find.sv
`timescale 1ns/1ps
module irq_prio_find #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter int VEC_W     = 8
) (
  input  logic [NUM_WORDS*WORD_W-1:0] bits_i,
  output logic                        found_o,
  output logic [VEC_W-1:0]            idx_o
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [NUM_WORDS-1:0]            word_any;
  logic [NUM_WORDS-1:0][BIT_W-1:0] word_msb;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word;
    logic [BIT_W-1:0]  msb;
    assign word = bits_i[w*WORD_W +: WORD_W];
    assign word_any[w] = |word;
    always_comb begin
      msb = '0;
      for (int b = 0; b < WORD_W; b++)
        if (word[b]) msb = BIT_W'(b);
    end
    assign word_msb[w] = msb;
  end

  always_comb begin
    found_o = |word_any;
    idx_o   = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (word_any[w]) idx_o = VEC_W'(w * WORD_W) + VEC_W'(word_msb[w]);
  end
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
  import irq_prio_pkg::*;
(
  input  vec_t tpr_i,
  input  logic isr_any_i,
  input  vec_t isr_top_i,
  input  logic irr_any_i,
  input  vec_t irr_top_i,
  output vec_t ppr_o,
  output logic deliver_o
);
  always_comb begin
    ppr_o     = calc_ppr(tpr_i, isr_any_i, isr_top_i);
    deliver_o = can_deliver(irr_any_i, irr_top_i, ppr_o);
  end
endmodule

// File: rtl/irq_prio_accept.sv
`timescale 1ns/1ps
module irq_prio_accept #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8,
  parameter int MIN_VEC = 16
) (
  input  logic               enable_i,
  input  logic               req_valid_i,
  input  logic [VEC_W-1:0]   req_vector_i,
  input  logic [NUM_VEC-1:0] irr_i,
  output logic               accept_o
);
  logic low_vec;
  assign low_vec  = (int'(req_vector_i) < MIN_VEC);
  assign accept_o = enable_i && req_valid_i && !low_vec && !irr_i[req_vector_i];
endmodule

// File: rtl/irq_prio_core.sv
`timescale 1ns/1ps
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MIN_VEC   = 16,
  parameter int TPR_BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable_i,
  input  logic                 req_valid_i,
  input  logic [7:0]           req_vector_i,
  input  logic                 req_level_i,
  output logic                 req_accept_o,
  input  logic                 tpr_we_i,
  input  logic [TPR_BUS_W-1:0] tpr_wdata_i,
  output logic [7:0]           ppr_o,
  output logic                 int_pending_o,
  output logic [7:0]           int_vector_o,
  input  logic                 ack_i,
  output logic                 ack_done_o,
  output logic [7:0]           ack_vector_o,
  input  logic                 eoi_i,
  output logic                 eoi_done_o,
  output logic [7:0]           eoi_vector_o,
  output logic                 eoi_level_o
);
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;

  // stored state
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  vec_t               tpr_q;

  // named internal events
  logic irr_any, isr_any, deliver, ack_fire, eoi_fire, req_take;
  vec_t irr_top, isr_top, ppr;

  irq_prio_find #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .VEC_W(VEC_W)) u_find_irr (
    .bits_i(irr_q), .found_o(irr_any), .idx_o(irr_top));

  irq_prio_find #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .VEC_W(VEC_W)) u_find_isr (
    .bits_i(isr_q), .found_o(isr_any), .idx_o(isr_top));

  irq_prio_arb u_arb (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_top_i(isr_top),
    .irr_any_i(irr_any), .irr_top_i(irr_top),
    .ppr_o(ppr), .deliver_o(deliver));

  irq_prio_accept #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .MIN_VEC(MIN_VEC)) u_accept (
    .enable_i(enable_i), .req_valid_i(req_valid_i), .req_vector_i(req_vector_i),
    .irr_i(irr_q), .accept_o(req_take));

  assign ack_fire = ack_i && deliver;
  assign eoi_fire = eoi_i && isr_any;

  // next-state: acknowledge, then retirement, then request (request wins on trigger bit)
  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_fire) begin
      isr_n[irr_top] = 1'b1;
      irr_n[irr_top] = 1'b0;
    end
    if (eoi_fire) begin
      isr_n[isr_top] = 1'b0;
      tmr_n[isr_top] = 1'b0;
    end
    if (req_take) begin
      irr_n[req_vector_i] = 1'b1;
      tmr_n[req_vector_i] = req_level_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q        <= '0;
      isr_q        <= '0;
      tmr_q        <= '0;
      tpr_q        <= '0;
      ack_done_o   <= 1'b0;
      ack_vector_o <= '0;
      eoi_done_o   <= 1'b0;
      eoi_vector_o <= '0;
      eoi_level_o  <= 1'b0;
    end else begin
      irr_q        <= irr_n;
      isr_q        <= isr_n;
      tmr_q        <= tmr_n;
      if (tpr_we_i) tpr_q <= tpr_wdata_i[VEC_W-1:0];
      ack_done_o   <= ack_fire;
      ack_vector_o <= ack_fire ? irr_top : '0;
      eoi_done_o   <= eoi_fire;
      eoi_vector_o <= eoi_fire ? isr_top : '0;
      eoi_level_o  <= eoi_fire && tmr_q[isr_top];
    end
  end

  assign req_accept_o  = req_take;
  assign ppr_o         = ppr;
  assign int_pending_o = deliver;
  assign int_vector_o  = irr_any ? irr_top : '0;
endmodule

// File: rtl/irq_prio_core_chk.sv
`timescale 1ns/1ps
module irq_prio_core_chk #(
  parameter int NUM_VEC   = 256,
  parameter int TPR_BUS_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 enable_i,
  input logic                 req_valid_i,
  input logic [7:0]           req_vector_i,
  input logic                 req_accept_o,
  input logic                 tpr_we_i,
  input logic [TPR_BUS_W-1:0] tpr_wdata_i,
  input logic [7:0]           ppr_o,
  input logic                 int_pending_o,
  input logic [7:0]           int_vector_o,
  input logic                 ack_i,
  input logic                 ack_done_o,
  input logic [7:0]           ack_vector_o,
  input logic                 eoi_i,
  input logic                 eoi_done_o,
  input logic                 isr_any,
  input logic [NUM_VEC-1:0]   irr_q
);
  // R8
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && int_pending_o) |=> (ack_done_o && ack_vector_o == $past(int_vector_o)));

  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_i && int_pending_o) |=> !ack_done_o);

  // R10
  eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !isr_any) |=> !eoi_done_o);

  // R4
  drop_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !enable_i) |-> !req_accept_o);

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    req_accept_o |=> irr_q[$past(req_vector_i)]);

  // R11
  ppr_floor_chk: assert property (@(posedge clk) disable iff (rst)
    tpr_we_i |=> (ppr_o >= {$past(tpr_wdata_i[7:4]), 4'h0}));

  // R7
  low_vec_chk: assert property (@(posedge clk) disable iff (rst)
    int_pending_o |-> (int_vector_o >= 8'd16));
endmodule

bind irq_prio_core irq_prio_core_chk #(.NUM_VEC(NUM_VEC), .TPR_BUS_W(TPR_BUS_W)) u_chk (
  .clk(clk), .rst(rst), .enable_i(enable_i), .req_valid_i(req_valid_i),
  .req_vector_i(req_vector_i), .req_accept_o(req_accept_o), .tpr_we_i(tpr_we_i),
  .tpr_wdata_i(tpr_wdata_i), .ppr_o(ppr_o), .int_pending_o(int_pending_o),
  .int_vector_o(int_vector_o), .ack_i(ack_i), .ack_done_o(ack_done_o),
  .ack_vector_o(ack_vector_o), .eoi_i(eoi_i), .eoi_done_o(eoi_done_o),
  .isr_any(isr_any), .irr_q(irr_q));

// File: tb/irq_prio_core_tb_top.sv
`timescale 1ns/100ps
module irq_prio_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable_i = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vector_i = '0;
  logic        req_level_i = 1'b0;
  logic        tpr_we_i = 1'b0;
  logic [31:0] tpr_wdata_i = '0;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        req_accept_o, int_pending_o, ack_done_o, eoi_done_o, eoi_level_o;
  logic [7:0]  ppr_o, int_vector_o, ack_vector_o, eoi_vector_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit run_cmp = 0;

  always #2 clk = ~clk;

  irq_prio_core dut_i (
    .clk(clk), .rst(rst), .enable_i(enable_i), .req_valid_i(req_valid_i),
    .req_vector_i(req_vector_i), .req_level_i(req_level_i), .req_accept_o(req_accept_o),
    .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i), .ppr_o(ppr_o),
    .int_pending_o(int_pending_o), .int_vector_o(int_vector_o), .ack_i(ack_i),
    .ack_done_o(ack_done_o), .ack_vector_o(ack_vector_o), .eoi_i(eoi_i),
    .eoi_done_o(eoi_done_o), .eoi_vector_o(eoi_vector_o), .eoi_level_o(eoi_level_o));

  // ---------------- behavioural reference ----------------
  bit m_irr[256];
  bit m_isr[256];
  bit m_tmr[256];
  int m_tpr;
  int e_ack_done, e_ack_vec, e_eoi_done, e_eoi_vec, e_eoi_lvl;

  function automatic int top_of(bit b[256]);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int s = top_of(m_isr);
    int sv = (s < 0) ? 0 : s;
    if ((m_tpr / 16) >= (sv / 16)) return m_tpr;
    return (sv / 16) * 16;
  endfunction

  function automatic bit m_pending();
    int t = top_of(m_irr);
    return (t >= 0) && ((t / 16) * 16 > m_ppr());
  endfunction

  function automatic bit m_accept();
    return enable_i && req_valid_i && (int'(req_vector_i) >= 16) && !m_irr[req_vector_i];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_irr[i]) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
      m_tpr = 0;
      e_ack_done = 0; e_ack_vec = 0; e_eoi_done = 0; e_eoi_vec = 0; e_eoi_lvl = 0;
    end else begin
      int it, st;
      bit acc, ackf, eoif;
      it   = top_of(m_irr);
      st   = top_of(m_isr);
      acc  = m_accept();
      ackf = ack_i && m_pending();
      eoif = eoi_i && (st >= 0);
      e_ack_done = ackf;
      e_ack_vec  = ackf ? it : 0;
      e_eoi_done = eoif;
      e_eoi_vec  = eoif ? st : 0;
      e_eoi_lvl  = eoif ? int'(m_tmr[st]) : 0;
      if (ackf) begin m_isr[it] = 1; m_irr[it] = 0; end
      if (eoif) begin m_isr[st] = 0; m_tmr[st] = 0; end
      if (acc) begin m_irr[req_vector_i] = 1; m_tmr[req_vector_i] = req_level_i; end
      if (tpr_we_i) m_tpr = int'(tpr_wdata_i[7:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #1;
    if (!rst && run_cmp) begin
      int t;
      t = top_of(m_irr);
      chk(int'(ppr_o) == m_ppr(), "R5", "ppr", ppr_o, m_ppr());
      chk(int_pending_o == m_pending(), "R6", "pending", int_pending_o, m_pending());
      chk(int'(int_vector_o) == ((t < 0) ? 0 : t), "R7", "vector", int_vector_o, (t < 0) ? 0 : t);
      if (req_valid_i)
        chk(req_accept_o == m_accept(), "R2", "accept", req_accept_o, m_accept());
      chk(int'(ack_done_o) == e_ack_done, "R8", "ack_done", ack_done_o, e_ack_done);
      chk(int'(ack_vector_o) == e_ack_vec, "R8", "ack_vector", ack_vector_o, e_ack_vec);
      chk(int'(eoi_done_o) == e_eoi_done, "R9", "eoi_done", eoi_done_o, e_eoi_done);
      chk(int'(eoi_vector_o) == e_eoi_vec, "R9", "eoi_vector", eoi_vector_o, e_eoi_vec);
      chk(int'(eoi_level_o) == e_eoi_lvl, "R9", "eoi_level", eoi_level_o, e_eoi_lvl);
    end
  end

  // drive one cycle of inputs at negedge + 0.5
  task automatic step(input bit rv, input int vec, input bit lvl, input bit ak,
                      input bit eo, input bit tw, input logic [31:0] td);
    @(negedge clk);
    #0.5;
    req_valid_i  = rv;
    req_vector_i = vec[7:0];
    req_level_i  = lvl;
    ack_i        = ak;
    eoi_i        = eo;
    tpr_we_i     = tw;
    tpr_wdata_i  = td;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    #0.5 rst = 1'b0;
    run_cmp = 1;
    idle(); #0.6;
    // R1 reset state
    chk(ppr_o == 8'h00, "R1", "ppr", ppr_o, 0);
    chk(int_pending_o == 1'b0, "R1", "pending", int_pending_o, 0);
    chk(int_vector_o == 8'h00, "R1", "vector", int_vector_o, 0);
    chk(ack_done_o == 1'b0 && eoi_done_o == 1'b0, "R1", "done", ack_done_o | eoi_done_o, 0);

    step(1, 'h31, 0, 0, 0, 0, 0); #0.6;
    chk(req_accept_o == 1'b1, "R2", "first request", req_accept_o, 1);
    step(1, 'h31, 1, 0, 0, 0, 0); #0.6;
    chk(req_accept_o == 1'b0, "R3", "duplicate request", req_accept_o, 0);
    step(1, 'h05, 0, 0, 0, 0, 0); #0.6;
    chk(req_accept_o == 1'b0, "R4", "low vector", req_accept_o, 0);
    step(1, 'h40, 0, 0, 0, 0, 0); enable_i = 1'b0; #0.6;
    chk(req_accept_o == 1'b0, "R4", "disabled", req_accept_o, 0);
    step(1, 'h45, 1, 0, 0, 0, 0); enable_i = 1'b1; #0.6;
    chk(req_accept_o == 1'b1, "R2", "level request", req_accept_o, 1);
    idle(); #0.6;
    chk(int_vector_o == 8'h45 && int_pending_o, "R7", "top vector", int_vector_o, 'h45);

    step(0, 0, 0, 0, 0, 1, 32'h1234_5650); idle(); #0.6;
    chk(ppr_o == 8'h50, "R11", "tpr low byte", ppr_o, 'h50);
    chk(int_pending_o == 1'b0, "R6", "masked by tpr", int_pending_o, 0);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0040); idle(); #0.6;
    chk(int_pending_o == 1'b0, "R6", "equal class masked", int_pending_o, 0);
    step(0, 0, 0, 0, 0, 1, 32'h0000_003F); idle(); #0.6;
    chk(int_pending_o == 1'b1, "R6", "class above", int_pending_o, 1);

    step(0, 0, 0, 1, 0, 0, 0); idle(); #0.6;
    chk(ack_done_o && ack_vector_o == 8'h45, "R8", "ack vector", ack_vector_o, 'h45);
    chk(ppr_o == 8'h40, "R5", "ppr from in-service", ppr_o, 'h40);
    step(0, 0, 0, 1, 0, 0, 0); idle(); #0.6;
    chk(ack_done_o == 1'b0, "R8", "ack ignored", ack_done_o, 0);

    step(1, 'h70, 0, 0, 0, 0, 0); step(0, 0, 0, 1, 0, 0, 0); idle(); #0.6;
    chk(ack_vector_o == 8'h70 && ppr_o == 8'h70, "R8", "nested ack", ack_vector_o, 'h70);
    step(0, 0, 0, 0, 1, 0, 0); idle(); #0.6;
    chk(eoi_done_o && eoi_vector_o == 8'h70 && !eoi_level_o, "R9", "retire edge", eoi_vector_o, 'h70);
    step(0, 0, 0, 0, 1, 0, 0); idle(); #0.6;
    chk(eoi_done_o && eoi_vector_o == 8'h45 && eoi_level_o, "R9", "retire level", eoi_vector_o, 'h45);
    step(0, 0, 0, 0, 1, 0, 0); idle(); #0.6;
    chk(eoi_done_o == 1'b0 && ppr_o == 8'h3F, "R10", "empty eoi", eoi_done_o, 0);

    step(0, 0, 0, 0, 0, 1, 32'h0);
    step(1, 'h60, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    step(1, 'h60, 0, 0, 1, 0, 0); #0.6;
    chk(req_accept_o == 1'b1, "R12", "request beside eoi", req_accept_o, 1);
    idle(); #0.6;
    chk(eoi_vector_o == 8'h60 && eoi_level_o, "R12", "old trigger reported", eoi_level_o, 1);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 0); idle(); #0.6;
    chk(eoi_vector_o == 8'h60 && !eoi_level_o, "R12", "new trigger kept", eoi_level_o, 0);
    step(1, 'h31, 1, 1, 0, 0, 0); #0.6;
    chk(req_accept_o == 1'b0, "R12", "request vs ack same vector", req_accept_o, 0);
    idle(); #0.6;
    chk(ack_vector_o == 8'h31 && int_vector_o == 8'h00, "R12", "ack wins", ack_vector_o, 'h31);
    step(0, 0, 0, 0, 1, 0, 0);

    // pseudo-random mix
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      int v;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      v = int'(lf[7:0]);
      enable_i = (lf[11:8] != 4'h0);
      step(lf[12] | lf[13], v, lf[14], lf[17:15] == 3'b000, lf[20:18] == 3'b000,
           lf[25:21] == 5'h00, {lf[31:26], lf[25:0]} ^ 32'h0000_0020);
    end
    enable_i = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    #1.5;
    finish_run();
  end
endmodule